// File: doc/BRIEF.md
# Scalar Four-Lane Swizzle Move Unit

The unit rearranges four 32-bit lanes held in a pair of 64-bit source words and produces a new pair of 64-bit destination words. A 12-bit immediate holds one 3-bit selector for each destination lane. A selector can copy any source lane into its lane, write a constant zero or a constant one, or leave the lane untouched. A selector can also end the active part of the swizzle early, which stops every later lane from being written.

Lanes that the swizzle does not write follow one of two rules. In an in-place move, where the destination pair is the source pair, they keep the old destination contents. In any other move they become zero. When saturation is on in integer mode, the constant-one selector writes the largest value of the lane type instead. In floating-point mode it writes single-precision one.

The unit registers all operands on one edge and computes the result from those registered copies. It registers the result and a valid flag on the next edge. Because both source words are held before anything is written, an in-place move cannot read back a half-written destination. Per-word write enables report which destination words need updating.

Top module: `swz_move_unit`

## Requirements
- R1: `imm_i[3k+2:3k]` is the selector of destination lane k. Source and destination lanes map the same way: lane 0 (X) is bits [31:0] of the low word, lane 1 (Y) is bits [63:32] of the low word, lane 2 (Z) is bits [31:0] of the high word, and lane 3 (W) is bits [63:32] of the high word.
- R2: A selector `1nn` writes source lane nn (0 to 3) into its destination lane.
- R3: Selector `010` writes 0x00000000 into the lane, in every mode.
- R4: In integer mode (`fp_i`=0) with `sat_i`=0, selector `011` writes 0x00000001.
- R5: In integer mode with `sat_i`=1, selector `011` writes 0x7FFFFFFF when `signed_i`=1 and 0xFFFFFFFF when `signed_i`=0.
- R6: In floating-point mode (`fp_i`=1), selector `011` writes 0x3F800000 whatever the value of `sat_i`.
- R7: Selector `000` leaves its lane unwritten.
- R8: Selector `001` marks the end. Its own lane and every higher lane are unwritten, whatever their selectors hold.
- R9: When `in_place_i`=1, an unwritten lane outputs the old destination lane from `dst_old_lo_i`/`dst_old_hi_i`.
- R10: When `in_place_i`=0, an unwritten lane outputs zero.
- R11: A request sampled with `valid_i`=1 on a rising edge produces `valid_o`=1 with its result after the second rising edge, and not after the first. `valid_o` is 0 in every cycle that has no such request.
- R12: The operands are captured on the edge that samples `valid_i`. Later changes to any data input do not change that result.
- R13: While `valid_o`=1, `we_lo_o`/`we_hi_o` is 1 for a word if `in_place_i` was 0, or if the swizzle writes at least one lane of that word. Both enables are 0 while `valid_o`=0.
- R14: While `rst_ni` is low, `valid_o`, both write enables and both data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| src_lo_i | input | 64 | Source word holding lanes X and Y |
| src_hi_i | input | 64 | Source word holding lanes Z and W |
| dst_old_lo_i | input | 64 | Current destination low word |
| dst_old_hi_i | input | 64 | Current destination high word |
| imm_i | input | 12 | Four 3-bit lane selectors |
| in_place_i | input | 1 | Destination pair is the source pair |
| fp_i | input | 1 | Floating-point constants |
| sat_i | input | 1 | Saturating constant one |
| signed_i | input | 1 | Saturated maximum is signed |
| valid_o | output | 1 | Result valid |
| dst_lo_o | output | 64 | New destination low word |
| dst_hi_o | output | 64 | New destination high word |
| we_lo_o | output | 1 | Write enable for the low word |
| we_hi_o | output | 1 | Write enable for the high word |

## Verification
The bench places an end marker in lane X and in lane Y, with active-looking selectors after it. A design that only skipped the marker lane would write those later lanes, and in an in-place move with the marker in X it would also raise write enables. The bench also drives skip patterns that cover only one destination word, once in place and once not. A design that mixed up the keep and zero rules would output stale data or zeros in the wrong lanes, or would report a wrong write enable. It then runs the constant-one selector through every mode combination, to catch a saturated maximum with the wrong sign or saturation leaking into floating-point mode. Finally it changes all data inputs in the cycle after capture, which exposes a design that reads its sources late.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int LANE_W     = 32;
  localparam int LANES      = 4;
  localparam int SEL_W      = 3;
  localparam int IDX_W      = $clog2(LANES);
  localparam int IMM_W      = LANES * SEL_W;
  localparam int WORD_LANES = 2;
  localparam int WORDS      = LANES / WORD_LANES;
  localparam int WORD_W     = LANE_W * WORD_LANES;
  localparam int DATA_W     = LANE_W * LANES;

  localparam logic [SEL_W-1:0] SEL_SKIP = 3'b000;
  localparam logic [SEL_W-1:0] SEL_END  = 3'b001;
  localparam logic [SEL_W-1:0] SEL_ZERO = 3'b010;
  localparam logic [SEL_W-1:0] SEL_ONE  = 3'b011;

  localparam logic [LANE_W-1:0] FP_ONE = 32'h3F80_0000;

  typedef struct packed {
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] old;
    logic [IMM_W-1:0]  imm;
    logic              in_place;
    logic              fp;
    logic              sat;
    logic              sgn;
  } swz_op_t;
endpackage

// File: rtl/swz_operand_reg.sv
module swz_operand_reg
  import swz_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    valid_i,
  input  swz_op_t op_i,
  output logic    valid_o,
  output swz_op_t op_o
);
  logic    valid_q;
  swz_op_t op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      op_q    <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) op_q <= op_i;
    end
  end

  assign valid_o = valid_q;
  assign op_o    = op_q;

  // R12
  hold_operands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(op_o));
endmodule

// File: rtl/swz_sel_decode.sv
module swz_sel_decode #(
  parameter int LANES = swz_pkg::LANES,
  parameter int SEL_W = swz_pkg::SEL_W,
  localparam int IDX_W = SEL_W - 1
) (
  input  logic [LANES*SEL_W-1:0] imm_i,
  output logic [LANES-1:0]       wr_o,
  output logic [LANES-1:0]       cnst_o,
  output logic [LANES-1:0]       one_o,
  output logic [LANES*IDX_W-1:0] idx_o
);
  import swz_pkg::*;

  logic [LANES-1:0] is_end;
  logic [LANES-1:0] stopped;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SEL_W-1:0] sel;
    assign sel       = imm_i[k*SEL_W +: SEL_W];
    assign is_end[k] = (sel == SEL_END);
    // marker lane and every later lane count as not written
    if (k == 0) begin : g_first
      assign stopped[k] = is_end[k];
    end else begin : g_rest
      assign stopped[k] = stopped[k-1] | is_end[k];
    end
    assign wr_o[k]   = !stopped[k] && (sel != SEL_SKIP);
    assign cnst_o[k] = !sel[SEL_W-1];
    assign one_o[k]  = (sel == SEL_ONE);
    assign idx_o[k*IDX_W +: IDX_W] = sel[IDX_W-1:0];
  end
endmodule

// File: rtl/swz_const_gen.sv
module swz_const_gen #(
  parameter int LANE_W = swz_pkg::LANE_W
) (
  input  logic              fp_i,
  input  logic              sat_i,
  input  logic              sgn_i,
  output logic [LANE_W-1:0] one_o
);
  import swz_pkg::*;

  logic [LANE_W-1:0] sat_max;
  assign sat_max = sgn_i ? {1'b0, {(LANE_W-1){1'b1}}} : {LANE_W{1'b1}};

  always_comb begin
    if (fp_i)       one_o = FP_ONE;
    else if (sat_i) one_o = sat_max;
    else            one_o = LANE_W'(1);
  end
endmodule

// File: rtl/swz_lane_xbar.sv
module swz_lane_xbar #(
  parameter int LANE_W = swz_pkg::LANE_W,
  parameter int LANES  = swz_pkg::LANES,
  localparam int IDX_W  = $clog2(LANES),
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic [DATA_W-1:0]      src_i,
  input  logic [DATA_W-1:0]      old_i,
  input  logic [LANES-1:0]       wr_i,
  input  logic [LANES-1:0]       cnst_i,
  input  logic [LANES-1:0]       one_i,
  input  logic [LANES*IDX_W-1:0] idx_i,
  input  logic [LANE_W-1:0]      one_val_i,
  input  logic                   in_place_i,
  output logic [DATA_W-1:0]      res_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IDX_W-1:0]  idx;
    logic [LANE_W-1:0] pick;
    assign idx  = idx_i[k*IDX_W +: IDX_W];
    assign pick = src_i[idx*LANE_W +: LANE_W];

    always_comb begin
      if (wr_i[k]) begin
        if (cnst_i[k]) res_o[k*LANE_W +: LANE_W] = one_i[k] ? one_val_i : '0;
        else           res_o[k*LANE_W +: LANE_W] = pick;
      end else begin
        res_o[k*LANE_W +: LANE_W] = in_place_i ? old_i[k*LANE_W +: LANE_W] : '0;
      end
    end
  end
endmodule

// File: rtl/swz_move_unit.sv
module swz_move_unit
  import swz_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] src_lo_i,
  input  logic [WORD_W-1:0] src_hi_i,
  input  logic [WORD_W-1:0] dst_old_lo_i,
  input  logic [WORD_W-1:0] dst_old_hi_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              in_place_i,
  input  logic              fp_i,
  input  logic              sat_i,
  input  logic              signed_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] dst_lo_o,
  output logic [WORD_W-1:0] dst_hi_o,
  output logic              we_lo_o,
  output logic              we_hi_o
);
  swz_op_t op_d, s1_op;
  logic    s1_valid;

  assign op_d = '{src: {src_hi_i, src_lo_i}, old: {dst_old_hi_i, dst_old_lo_i},
                  imm: imm_i, in_place: in_place_i, fp: fp_i, sat: sat_i, sgn: signed_i};

  swz_operand_reg u_opreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .op_i   (op_d),
    .valid_o(s1_valid),
    .op_o   (s1_op)
  );

  logic [LANES-1:0]       wr, cnst, one;
  logic [LANES*IDX_W-1:0] idx;
  logic [LANE_W-1:0]      one_val;
  logic [DATA_W-1:0]      res;
  logic [WORDS-1:0]       we_d;

  swz_sel_decode #(.LANES(LANES), .SEL_W(SEL_W)) u_dec (
    .imm_i (s1_op.imm),
    .wr_o  (wr),
    .cnst_o(cnst),
    .one_o (one),
    .idx_o (idx)
  );

  swz_const_gen #(.LANE_W(LANE_W)) u_const (
    .fp_i (s1_op.fp),
    .sat_i(s1_op.sat),
    .sgn_i(s1_op.sgn),
    .one_o(one_val)
  );

  swz_lane_xbar #(.LANE_W(LANE_W), .LANES(LANES)) u_xbar (
    .src_i     (s1_op.src),
    .old_i     (s1_op.old),
    .wr_i      (wr),
    .cnst_i    (cnst),
    .one_i     (one),
    .idx_i     (idx),
    .one_val_i (one_val),
    .in_place_i(s1_op.in_place),
    .res_o     (res)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_we
    assign we_d[w] = !s1_op.in_place || (|wr[w*WORD_LANES +: WORD_LANES]);
  end

  logic [DATA_W-1:0] res_q;
  logic [WORDS-1:0]  we_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      we_q    <= '0;
      res_q   <= '0;
    end else begin
      valid_q <= s1_valid;
      we_q    <= s1_valid ? we_d : '0;
      if (s1_valid) res_q <= res;
    end
  end

  assign valid_o  = valid_q;
  assign we_lo_o  = we_q[0];
  assign we_hi_o  = we_q[1];
  assign dst_lo_o = res_q[0 +: WORD_W];
  assign dst_hi_o = res_q[WORD_W +: WORD_W];

  // R11
  valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(s1_valid));

  // R13
  we_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!we_lo_o && !we_hi_o));

  // R10
  zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(s1_op.in_place) && $past(s1_op.imm[SEL_W-1:0]) == SEL_SKIP)
      |-> dst_lo_o[LANE_W-1:0] == '0);

  // R9
  keep_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(s1_op.in_place) && $past(s1_op.imm[SEL_W-1:0]) == SEL_SKIP)
      |-> dst_lo_o[LANE_W-1:0] == $past(s1_op.old[LANE_W-1:0]));

  // R3
  zero_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(s1_op.imm[2*SEL_W-1:SEL_W]) == SEL_ZERO
             && $past(s1_op.imm[SEL_W-1:0]) != SEL_END)
      |-> dst_lo_o[WORD_W-1:LANE_W] == '0);

  // R13
  in_place_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(s1_op.in_place) && $past(s1_op.imm[SEL_W-1:0]) == SEL_END)
      |-> (!we_lo_o && !we_hi_o));
endmodule

// File: tb/swz_move_unit_tb.sv
module swz_move_unit_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic        valid_i = 1'b0;
  logic [63:0] src_lo_i = '0, src_hi_i = '0, dst_old_lo_i = '0, dst_old_hi_i = '0;
  logic [11:0] imm_i = '0;
  logic        in_place_i = 1'b0, fp_i = 1'b0, sat_i = 1'b0, signed_i = 1'b0;
  logic        valid_o, we_lo_o, we_hi_o;
  logic [63:0] dst_lo_o, dst_hi_o;

  swz_move_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .src_lo_i(src_lo_i), .src_hi_i(src_hi_i),
    .dst_old_lo_i(dst_old_lo_i), .dst_old_hi_i(dst_old_hi_i),
    .imm_i(imm_i), .in_place_i(in_place_i), .fp_i(fp_i), .sat_i(sat_i), .signed_i(signed_i),
    .valid_o(valid_o), .dst_lo_o(dst_lo_o), .dst_hi_o(dst_hi_o),
    .we_lo_o(we_lo_o), .we_hi_o(we_hi_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] q_lo[$], q_hi[$];
  logic [1:0]  q_we[$];
  string       q_tag[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic model(input logic [11:0] imm, input logic [63:0] slo, shi, olo, ohi,
                       input logic inpl, fp, sat, sgn,
                       output logic [63:0] rlo, rhi, output logic [1:0] we);
    logic [31:0] s[4];
    logic [31:0] o[4];
    logic [31:0] r[4];
    logic [31:0] one;
    bit          w[4];
    bit          stop;
    s[0] = slo[31:0]; s[1] = slo[63:32]; s[2] = shi[31:0]; s[3] = shi[63:32];
    o[0] = olo[31:0]; o[1] = olo[63:32]; o[2] = ohi[31:0]; o[3] = ohi[63:32];
    if (fp)       one = 32'h3F80_0000;
    else if (sat) one = sgn ? 32'h7FFF_FFFF : 32'hFFFF_FFFF;
    else          one = 32'h1;
    stop = 0;
    for (int k = 0; k < 4; k++) begin
      logic [2:0] sel;
      sel  = imm[3*k +: 3];
      w[k] = 0;
      r[k] = '0;
      if (sel == 3'b001) stop = 1;
      if (!stop) begin
        if (sel == 3'b010)      begin w[k] = 1; r[k] = '0;  end
        else if (sel == 3'b011) begin w[k] = 1; r[k] = one; end
        else if (sel[2])        begin w[k] = 1; r[k] = s[sel[1:0]]; end
      end
      if (!w[k]) r[k] = inpl ? o[k] : '0;
    end
    rlo = {r[1], r[0]};
    rhi = {r[3], r[2]};
    we  = {!inpl || w[2] || w[3], !inpl || w[0] || w[1]};
  endtask

  task automatic send(input logic [11:0] imm, input logic [63:0] slo, shi, olo, ohi,
                      input logic inpl, fp, sat, sgn, input string tag);
    logic [63:0] rlo, rhi;
    logic [1:0]  we;
    model(imm, slo, shi, olo, ohi, inpl, fp, sat, sgn, rlo, rhi, we);
    q_lo.push_back(rlo); q_hi.push_back(rhi); q_we.push_back(we); q_tag.push_back(tag);
    imm_i = imm; src_lo_i = slo; src_hi_i = shi; dst_old_lo_i = olo; dst_old_hi_i = ohi;
    in_place_i = inpl; fp_i = fp; sat_i = sat; signed_i = sgn;
    valid_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    valid_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (q_lo.size() == 0) begin
          check(0, "R11", "unexpected valid_o", 128'(valid_o), 128'(0));
        end else begin
          logic [63:0] elo, ehi;
          logic [1:0]  ewe;
          string       t;
          elo = q_lo.pop_front(); ehi = q_hi.pop_front();
          ewe = q_we.pop_front(); t = q_tag.pop_front();
          check({dst_hi_o, dst_lo_o} == {ehi, elo}, t, "data",
                {dst_hi_o, dst_lo_o}, {ehi, elo});
          check({we_hi_o, we_lo_o} == ewe, t, "write enables",
                128'({we_hi_o, we_lo_o}), 128'(ewe));
        end
      end else if (we_lo_o || we_hi_o) begin
        check(0, "R13", "enable without valid", 128'({we_hi_o, we_lo_o}), 128'(0));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  localparam logic [63:0] SLO = 64'h2222_2222_1111_1111; // Y=2222.. X=1111..
  localparam logic [63:0] SHI = 64'h4444_4444_3333_3333; // W=4444.. Z=3333..
  localparam logic [63:0] OLO = 64'hBBBB_BBBB_AAAA_AAAA;
  localparam logic [63:0] OHI = 64'hDDDD_DDDD_CCCC_CCCC;

  initial begin
    repeat (3) @(negedge clk);
    // R14 reset state
    check(valid_o == 1'b0, "R14", "valid_o in reset", 128'(valid_o), 128'(0));
    check({we_hi_o, we_lo_o} == 2'b00, "R14", "we in reset", 128'({we_hi_o, we_lo_o}), 128'(0));
    check({dst_hi_o, dst_lo_o} == '0, "R14", "data in reset", {dst_hi_o, dst_lo_o}, 128'(0));
    rst_ni = 1'b1;
    idle(2);

    // R11 latency: nothing after one edge, result after two
    send(12'hFAC, SLO, SHI, OLO, OHI, 0, 0, 0, 0, "R1 R2 identity");
    valid_i = 1'b0;
    check(valid_o == 1'b0, "R11", "valid_o one edge after request", 128'(valid_o), 128'(0));
    @(negedge clk);
    check(valid_o == 1'b1, "R11", "valid_o two edges after request", 128'(valid_o), 128'(1));
    idle(2);

    send(12'h977, SLO, SHI, OLO, OHI, 0, 0, 0, 0, "R2 reverse");
    send(12'hB6D, SLO, SHI, OLO, OHI, 1, 0, 0, 0, "R2 broadcast Y");
    // constants: X=0 Y=1 Z=1 W=0
    send(12'h4DA, SLO, SHI, OLO, OHI, 0, 0, 0, 0, "R3 R4 int constants");
    send(12'h4DA, SLO, SHI, OLO, OHI, 0, 0, 1, 1, "R5 signed max");
    send(12'h4DA, SLO, SHI, OLO, OHI, 0, 0, 1, 0, "R5 unsigned max");
    send(12'h4DA, SLO, SHI, OLO, OHI, 0, 1, 0, 0, "R6 fp one");
    send(12'h4DA, SLO, SHI, OLO, OHI, 0, 1, 1, 1, "R6 fp one with sat");
    // skip pattern: X<-W, Y skip, Z<-Y, W skip
    send(12'h147, SLO, SHI, OLO, OHI, 0, 0, 0, 0, "R7 R10 skip zeroed");
    send(12'h147, SLO, SHI, OLO, OHI, 1, 0, 0, 0, "R7 R9 skip kept");
    // end marker in Y, later lanes look active
    send(12'hD0D, SLO, SHI, OLO, OHI, 1, 0, 0, 0, "R8 R9 end at Y");
    send(12'hD0D, SLO, SHI, OLO, OHI, 0, 0, 0, 0, "R8 R10 end at Y");
    // end marker in X: nothing written
    send(12'hD61, SLO, SHI, OLO, OHI, 1, 0, 0, 0, "R8 R13 end at X in place");
    send(12'hD61, SLO, SHI, OLO, OHI, 0, 0, 0, 0, "R8 R13 end at X");
    // only high word written in place
    send(12'hB00, SLO, SHI, OLO, OHI, 1, 0, 0, 0, "R13 high word only");
    send(12'h00C, SLO, SHI, OLO, OHI, 1, 0, 0, 0, "R13 low word only");
    idle(4);

    // R12: inputs change right after capture
    send(12'h977, SLO, SHI, OLO, OHI, 1, 0, 0, 0, "R12 late input change");
    valid_i = 1'b0;
    src_lo_i = ~SLO; src_hi_i = ~SHI; dst_old_lo_i = ~OLO; dst_old_hi_i = ~OHI;
    imm_i = 12'h000; in_place_i = 1'b0; fp_i = 1'b1;
    idle(4);

    for (int i = 0; i < 80; i++) begin
      send(12'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
           {$urandom, $urandom}, {$urandom, $urandom},
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R1 R2 R8 random");
      if ((i % 7) == 0) idle(1);
    end
    idle(5);
    check(q_lo.size() == 0, "R11", "results outstanding", 128'(q_lo.size()), 128'(0));

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule